// File: doc/BRIEF.md
# Not-Recently-Used Page Frame Victim Selector

This block keeps a referenced flag and a modified flag for each of a set of physical page frames and, when asked, names a frame to evict. Read and write accesses mark frames as used (writes also mark them dirty), loading a new page into a frame wipes both flags, and a divided-down periodic tick ages every frame by wiping the referenced flags while leaving the dirty flags alone.

A caller asks for a victim over a valid/ready request channel and receives the answer over a valid/ready result channel. Each frame falls into one of four classes, class index = 2*R + M, and class 0 is the cheapest to evict. The victim comes from the lowest class that has any member. Among the members of that class the pick is pseudo-random: a free-running LFSR supplies a start frame and a circular scan takes the first member it meets. The result carries the frame index and that frame's dirty flag, so the caller knows whether a write-back is needed. Back-pressure rules: a request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from that cycle until the result has been taken. The result stays on the outputs, unchanged, while `vic_valid` is high and `vic_ready` is low. The frame count must be at least 2.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every frame has R=0 and M=0, `req_ready` is 1 and `vic_valid` is 0.
- R2: A cycle with `rd_en` high sets R of frame `rd_idx`.
- R3: A cycle with `wr_en` high sets both R and M of frame `wr_idx`.
- R4: A cycle with `ld_en` high clears R and M of frame `ld_idx`, unless a read or write hits the same frame in that cycle, in which case the access takes effect.
- R5: Every TICKS_PER_CLEAR-th `tick` pulse, counted from reset, clears R of every frame on that cycle's edge. A read or write in that same cycle leaves R set on its frame.
- R6: The victim lies in the lowest non-empty class, with class = 2*R + M (0: unused clean, 1: unused dirty, 2: used clean, 3: used dirty). `vic_dirty` equals the victim's M flag. The class is judged from the flags as they stand in the acceptance cycle.
- R7: Within the chosen class the pick starts at an LFSR-derived frame and scans upward with wraparound, so repeated requests over a class with several members return more than one distinct frame.
- R8: `req_ready` is low from acceptance until the result is taken. `vic_valid` rises within FRAMES+1 cycles of acceptance. `vic_idx` and `vic_dirty` hold stable while `vic_valid` is high and `vic_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read access strobe |
| rd_idx | input | IDX_W | Frame index of the read |
| wr_en | input | 1 | Write access strobe |
| wr_idx | input | IDX_W | Frame index of the write |
| ld_en | input | 1 | Frame-loaded strobe |
| ld_idx | input | IDX_W | Frame index of the load |
| tick | input | 1 | Periodic aging tick |
| req_valid | input | 1 | Victim request valid |
| req_ready | output | 1 | Block can accept a request |
| vic_valid | output | 1 | Victim result valid |
| vic_ready | input | 1 | Caller takes the result |
| vic_idx | output | IDX_W | Chosen frame |
| vic_dirty | output | 1 | M flag of the chosen frame |

## Verification
The hardest case to reach from the ports is a read landing on the very cycle the aging sweep fires. Reaching it takes an exact count of tick pulses and a read placed alongside the last one. The bench first dirties every frame except one, pulses the tick one short of the divide ratio, then issues the final tick together with a read of the spare frame. After that, only an access that beats the sweep keeps that frame out of the cheapest class. The flag state is only visible through victim choices, so the stimulus arranges states in which the lowest class has exactly one member.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef enum logic [1:0] {
    CLS_IDLE_CLEAN = 2'd0,
    CLS_IDLE_DIRTY = 2'd1,
    CLS_USED_CLEAN = 2'd2,
    CLS_USED_DIRTY = 2'd3
  } nru_class_e;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_SCAN = 2'd1,
    SEL_DONE = 2'd2
  } sel_state_e;
endpackage

// File: rtl/nru_flag_bank.sv
module nru_flag_bank #(
  parameter int FRAMES          = 8,
  parameter int TICKS_PER_CLEAR = 4,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int CNT_W = (TICKS_PER_CLEAR > 1) ? $clog2(TICKS_PER_CLEAR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              tick,
  output logic [FRAMES-1:0] ref_q,
  output logic [FRAMES-1:0] mod_q
);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_CLEAR - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             sweep;

  assign sweep = tick && (tick_cnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rst_n)      tick_cnt <= '0;
    else if (sweep)  tick_cnt <= '0;
    else if (tick)   tick_cnt <= tick_cnt + 1'b1;
  end

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    logic rd_hit, wr_hit, ld_hit;
    assign rd_hit = rd_en && (rd_idx == IDX_W'(f));
    assign wr_hit = wr_en && (wr_idx == IDX_W'(f));
    assign ld_hit = ld_en && (ld_idx == IDX_W'(f));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_q[f] <= 1'b0;
        mod_q[f] <= 1'b0;
      end else begin
        ref_q[f] <= (ref_q[f] & ~sweep & ~ld_hit) | rd_hit | wr_hit;
        mod_q[f] <= (mod_q[f] & ~ld_hit) | wr_hit;
      end
    end
  end

  AST_READ_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ref_q[$past(rd_idx)]); // R2
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ref_q[$past(wr_idx)] && mod_q[$past(wr_idx)])); // R3
  AST_LOAD_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(rd_en && rd_idx == ld_idx) && !(wr_en && wr_idx == ld_idx))
    |=> (!ref_q[$past(ld_idx)] && !mod_q[$past(ld_idx)])); // R4
  AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep && !rd_en && !wr_en) |=> (ref_q == '0)); // R5
  AST_DIRTY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ((mod_q & $past(mod_q)) == $past(mod_q))); // R5
endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          state_q <= W'(1);
    else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
    else                 state_q <= state_q >> 1;
  end

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R7
endmodule

// File: rtl/nru_scan.sv
module nru_scan
  import nru_pkg::*;
#(
  parameter int FRAMES = 8,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAMES-1:0] ref_flags,
  input  logic [FRAMES-1:0] mod_flags,
  input  logic [IDX_W-1:0]  start_off,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              vic_valid,
  input  logic              vic_ready,
  output logic [IDX_W-1:0]  vic_idx,
  output logic              vic_dirty
);
  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAMES - 1);

  sel_state_e        state_q;
  logic [FRAMES-1:0] snap_r, snap_m;
  nru_class_e        tgt_q;
  logic [IDX_W-1:0]  ptr_q;
  nru_class_e        live_low, snap_low;
  nru_class_e        ptr_cls;

  function automatic nru_class_e lowest(input logic [FRAMES-1:0] r,
                                        input logic [FRAMES-1:0] m);
    logic [3:0] present;
    present = '0;
    for (int i = 0; i < FRAMES; i++) present[{r[i], m[i]}] = 1'b1;
    if (present[0])      return CLS_IDLE_CLEAN;
    else if (present[1]) return CLS_IDLE_DIRTY;
    else if (present[2]) return CLS_USED_CLEAN;
    else                 return CLS_USED_DIRTY;
  endfunction

  assign live_low  = lowest(ref_flags, mod_flags);
  assign snap_low  = lowest(snap_r, snap_m);
  assign ptr_cls   = nru_class_e'({snap_r[ptr_q], snap_m[ptr_q]});
  assign req_ready = (state_q == SEL_IDLE);
  assign vic_valid = (state_q == SEL_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SEL_IDLE;
      snap_r    <= '0;
      snap_m    <= '0;
      tgt_q     <= CLS_IDLE_CLEAN;
      ptr_q     <= '0;
      vic_idx   <= '0;
      vic_dirty <= 1'b0;
    end else begin
      unique case (state_q)
        SEL_IDLE: if (req_valid) begin
          snap_r  <= ref_flags;
          snap_m  <= mod_flags;
          tgt_q   <= live_low;
          ptr_q   <= start_off;
          state_q <= SEL_SCAN;
        end
        SEL_SCAN: begin
          if (ptr_cls == tgt_q) begin
            vic_idx   <= ptr_q;
            vic_dirty <= snap_m[ptr_q];
            state_q   <= SEL_DONE;
          end else begin
            ptr_q <= (ptr_q == LAST_FRAME) ? '0 : ptr_q + 1'b1;
          end
        end
        SEL_DONE: if (vic_ready) state_q <= SEL_IDLE;
        default: state_q <= SEL_IDLE;
      endcase
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_idx) && $stable(vic_dirty))); // R8
  AST_CHANNEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && vic_valid)); // R8
  AST_LOWEST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (({snap_r[vic_idx], snap_m[vic_idx]} == tgt_q) && (tgt_q == snap_low))); // R6
  AST_DIRTY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (vic_dirty == snap_m[vic_idx])); // R6
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int FRAMES          = 8,
  parameter int TICKS_PER_CLEAR = 4,
  parameter int LFSR_W          = 16,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             tick,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_dirty
);
  logic [FRAMES-1:0] ref_q, mod_q;
  logic [LFSR_W-1:0] rnd;
  logic [IDX_W-1:0]  raw_off, start_off;

  nru_flag_bank #(.FRAMES(FRAMES), .TICKS_PER_CLEAR(TICKS_PER_CLEAR)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .ld_en(ld_en), .ld_idx(ld_idx),
    .tick(tick), .ref_q(ref_q), .mod_q(mod_q)
  );

  nru_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(16'hB400))) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state_q(rnd)
  );

  assign raw_off = rnd[IDX_W-1:0];

  generate
    if ((1 << IDX_W) == FRAMES) begin : g_pow2
      assign start_off = raw_off;
    end else begin : g_fold
      assign start_off = (raw_off >= IDX_W'(FRAMES)) ? raw_off - IDX_W'(FRAMES) : raw_off;
    end
  endgenerate

  nru_scan #(.FRAMES(FRAMES)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .ref_flags(ref_q), .mod_flags(mod_q), .start_off(start_off),
    .req_valid(req_valid), .req_ready(req_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready),
    .vic_idx(vic_idx), .vic_dirty(vic_dirty)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !vic_valid)); // R1
endmodule

// File: tb/nru_victim_sel_tb.sv
module nru_victim_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 8;
  localparam int TICKS  = 4;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 0, wr_en = 0, ld_en = 0, tick = 0, req_valid = 0, vic_ready = 0;
  logic [IDX_W-1:0] rd_idx = '0, wr_idx = '0, ld_idx = '0;
  logic req_ready, vic_valid, vic_dirty;
  logic [IDX_W-1:0] vic_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nru_victim_sel #(.FRAMES(FRAMES), .TICKS_PER_CLEAR(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .ld_en(ld_en), .ld_idx(ld_idx), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready),
    .vic_idx(vic_idx), .vic_dirty(vic_dirty)
  );

  // {read mask, write mask, load mask, expected index, expected dirty}
  localparam int NVEC = 6;
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h7F, 8'h00, 8'h00, 3'd7, 1'b0},
    {8'h00, 8'hFE, 8'h00, 3'd0, 1'b0},
    {8'h00, 8'h00, 8'h10, 3'd4, 1'b0},
    {8'h00, 8'h10, 8'h00, 3'd0, 1'b0},
    {8'h00, 8'h00, 8'h02, 3'd1, 1'b0},
    {8'h02, 8'h01, 8'h00, 3'd1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic apply_masks(input logic [7:0] rm, input logic [7:0] wm, input logic [7:0] lm);
    for (int i = 0; i < FRAMES; i++) if (rm[i]) begin
      @(negedge clk); rd_en = 1; rd_idx = IDX_W'(i);
      @(negedge clk); rd_en = 0;
    end
    for (int i = 0; i < FRAMES; i++) if (wm[i]) begin
      @(negedge clk); wr_en = 1; wr_idx = IDX_W'(i);
      @(negedge clk); wr_en = 0;
    end
    for (int i = 0; i < FRAMES; i++) if (lm[i]) begin
      @(negedge clk); ld_en = 1; ld_idx = IDX_W'(i);
      @(negedge clk); ld_en = 0;
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic do_req(input int hold, output int idx, output bit dirty);
    int lat;
    @(negedge clk);
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    chk(!req_ready, "R8 req_ready low after accept", req_ready, 0);
    while (!vic_valid && lat < FRAMES + 4) begin
      @(negedge clk);
      lat++;
    end
    chk(vic_valid && lat <= FRAMES + 1, "R8 latency", lat, FRAMES + 1);
    idx = vic_idx;
    dirty = vic_dirty;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(vic_valid && vic_idx == IDX_W'(idx) && vic_dirty == dirty && !req_ready,
          "R8 result held under back-pressure", vic_idx, idx);
    end
    vic_ready = 1;
    @(negedge clk);
    vic_ready = 0;
    chk(req_ready && !vic_valid, "R8 ready again after take", req_ready, 1);
  endtask

  initial begin
    int idx;
    bit dirty;
    bit seen [FRAMES];
    int distinct;

    do_reset();
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    chk(vic_valid == 1'b0, "R1 vic_valid after reset", vic_valid, 0);
    do_req(0, idx, dirty);
    chk(dirty == 1'b0, "R1 flags clear after reset", dirty, 0);

    // table walk: R2 reads, R3 writes, R4 loads, R6 class pick
    for (int v = 0; v < NVEC; v++) begin
      apply_masks(VEC[v][27:20], VEC[v][19:12], VEC[v][11:4]);
      do_req(0, idx, dirty);
      chk(idx == int'(VEC[v][3:1]), $sformatf("R2/R3/R4/R6 vector %0d index", v), idx, VEC[v][3:1]);
      chk(dirty == VEC[v][0], $sformatf("R6 vector %0d dirty", v), dirty, VEC[v][0]);
    end

    // R5 aging sweep: frame 3 dirty, others used clean
    do_reset();
    apply_masks(8'hF7, 8'h08, 8'h00);
    pulse_ticks(TICKS - 1);
    do_req(0, idx, dirty);
    chk(idx != 3 && dirty == 0, "R5 no sweep before count reached", idx, 0);
    pulse_ticks(1);
    do_req(0, idx, dirty);
    chk(idx != 3 && dirty == 0, "R5 sweep puts clean frames in class 0", idx, 0);
    apply_masks(8'hF7, 8'h00, 8'h00);
    do_req(0, idx, dirty);
    chk(idx == 3, "R5 M kept through sweep, frame 3 in class 1", idx, 3);
    chk(dirty == 1, "R6 dirty reported for class 1 victim", dirty, 1);

    // R5 access on the sweep cycle wins
    do_reset();
    apply_masks(8'h00, 8'hDF, 8'h00);
    pulse_ticks(TICKS - 1);
    @(negedge clk); tick = 1; rd_en = 1; rd_idx = 3'd5;
    @(negedge clk); tick = 0; rd_en = 0;
    do_req(0, idx, dirty);
    chk(idx != 5, "R5 read on sweep cycle keeps R set", idx, 0);
    chk(dirty == 1, "R5 victim drawn from class 1", dirty, 1);

    // R4 load and write on the same frame in one cycle
    do_reset();
    apply_masks(8'hFB, 8'h00, 8'h00);
    @(negedge clk); ld_en = 1; ld_idx = 3'd2; wr_en = 1; wr_idx = 3'd2;
    @(negedge clk); ld_en = 0; wr_en = 0;
    do_req(0, idx, dirty);
    chk(idx != 2 && dirty == 0, "R4 access beats load on same frame", idx, 0);

    // R8 back-pressure hold
    do_req(5, idx, dirty);
    chk(idx != 2, "R8 held result is a valid pick", idx, 0);

    // R7 spread within a full class
    do_reset();
    for (int i = 0; i < FRAMES; i++) seen[i] = 0;
    for (int r = 0; r < 10; r++) begin
      do_req(0, idx, dirty);
      seen[idx] = 1;
      repeat (r % 3) @(negedge clk);
    end
    distinct = 0;
    for (int i = 0; i < FRAMES; i++) if (seen[i]) distinct++;
    chk(distinct >= 2, "R7 several distinct picks", distinct, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule